// File: doc/BRIEF.md
# GPIO Port with Peripheral Overrides

This block is an eight-pin general-purpose I/O port. Software programs a direction byte and an output-data byte over a small byte-wide register bus. Each pin then drives the pad ring with an output-enable, an output value and an open-drain select. Pad inputs pass through a two-stage synchronizer. Their values come back on two read registers: a port register that mixes output latches and inputs, and an input-only register.

Three peripheral requests can take pins away from the direction byte, in a fixed priority:

- The display-segment enable is the strongest. It turns every pin fully off, with both input and output disabled.
- The two-wire serial request comes next. On pins 6 and 5 it makes the pin an open-drain output.
- The per-pin timer compare requests come last. On pins 3 to 0 they force a push-pull output.

Pins 7 and 4 respond only to the display-segment enable.

The register bus is a plain control interface. A write completes in the cycle that `bus_sel` and `bus_wr` are high. A read is combinational from `bus_addr`. There is no valid/ready handshake and no back-pressure: the port takes every access at once. The override requests are plain level signals as well.

Top module: `gpio_port_ovr`

## Requirements
- R1: While reset is active and right after it, the direction and data bytes read back as 0, and every `pad_oe`, `pad_out` and `pad_od` bit is 0, so all pins are inputs.
- R2: With no override on a pin, direction bit 1 gives `pad_oe`=1, `pad_out`=data bit and `pad_od`=0. Direction bit 0 gives `pad_oe`=0 and `pad_out`=0.
- R3: While `lcd_seg_en`=1, every pin has `pad_oe`=0, `pad_out`=0 and `pad_od`=0, and reads as 0 in both the port register and the input register. This holds whatever the other requests and the direction byte are.
- R4: While `iic_route_en`=1 and `lcd_seg_en`=0, pins 6 and 5 have `pad_od`=1, `pad_out`=0 and `pad_oe`=NOT data bit. Their port-register bit returns the data bit.
- R5: While `tmr_oc_en[i]`=1 for a pin i in 3..0, and neither higher override applies, that pin has `pad_oe`=1 and `pad_out`=data bit, whatever its direction bit is.
- R6: Pins 7 and 4 ignore `iic_route_en` and `tmr_oc_en`. Only their direction bit and `lcd_seg_en` decide their outputs. Timer bits 7..4 have no effect on any pin.
- R7: A port-register read returns the data bit for pins that are effectively outputs (push-pull or open-drain). It returns the synchronized pad value for pins that are inputs.
- R8: A pad change applied just after a clock edge appears in the input and port reads after exactly two rising edges. After one edge the old value is still read.
- R9: Register map: data at address 0 (read/write), input at address 1 (read-only), direction at address 2 (read/write). Address 3 reads 0. A write to address 1 or 3 changes neither the data byte nor the direction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| lcd_seg_en | input | 1 | Display-segment enable, disables all pins |
| iic_route_en | input | 1 | Two-wire serial routed and enabled |
| tmr_oc_en | input | 8 | Per-pin timer compare routed and enabled (bits 3..0 used) |
| pad_in | input | 8 | Raw pad inputs |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_od | output | 8 | Pad open-drain select |

## Verification
The assertions assume that the override requests and the bus are stable around the rising edge. They also assume that `pad_in` may be asynchronous, so its value is checked only after the synchronizer. The stimulus changes every input half a cycle away from the rising edge. Pads are held steady for at least three edges before any read-back check, except in the directed latency test, which probes the one-edge and two-edge points on purpose. Random override combinations include all four priority overlaps, so each assertion sees its antecedent under mixed conditions.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NPINS = 8;

  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_INP  = 2'd1,
    ADR_DIR  = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PM_INPUT = 2'd0,
    PM_PUSH  = 2'd1,
    PM_OPEND = 2'd2,
    PM_OFF   = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = NPINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q
);
  logic wr_en;
  assign wr_en = bus_sel && bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      if (bus_addr == ADR_DATA) data_q <= bus_wdata;
      if (bus_addr == ADR_DIR)  dir_q  <= bus_wdata;
    end
  end

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (bus_addr == ADR_INP || bus_addr == ADR_NONE)) |=> ($stable(data_q) && $stable(dir_q))); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_ctl.sv
module gpio_ovr_ctl
  import gpio_pkg::*;
#(
  parameter int           W        = NPINS,
  parameter logic [W-1:0] IIC_MASK = 8'h60,
  parameter logic [W-1:0] TMR_MASK = 8'h0F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lcd_seg_en,
  input  logic         iic_route_en,
  input  logic [W-1:0] tmr_oc_en,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_od,
  output logic [W-1:0] is_out,
  output logic [W-1:0] in_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e mode;

    always_comb begin
      if (lcd_seg_en)                         mode = PM_OFF;
      else if (IIC_MASK[i] && iic_route_en)   mode = PM_OPEND;
      else if (TMR_MASK[i] && tmr_oc_en[i])   mode = PM_PUSH;
      else if (dir_q[i])                      mode = PM_PUSH;
      else                                    mode = PM_INPUT;
    end

    always_comb begin
      pad_oe[i]  = 1'b0;
      pad_out[i] = 1'b0;
      pad_od[i]  = 1'b0;
      is_out[i]  = 1'b0;
      in_en[i]   = 1'b1;
      case (mode)
        PM_PUSH: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = data_q[i];
          is_out[i]  = 1'b1;
        end
        PM_OPEND: begin
          pad_oe[i] = ~data_q[i];
          pad_od[i] = 1'b1;
          is_out[i] = 1'b1;
        end
        PM_OFF:  in_en[i] = 1'b0;
        default: ;
      endcase
    end
  end

  AST_LCD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_seg_en |-> (pad_oe == '0 && pad_od == '0 && in_en == '0)); // R3
  AST_OD_ON_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (iic_route_en && !lcd_seg_en) |-> ((pad_od & IIC_MASK) == IIC_MASK)); // R4
  AST_TMR_FORCES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_seg_en && !iic_route_en) |-> ((pad_oe & tmr_oc_en & TMR_MASK) == (tmr_oc_en & TMR_MASK))); // R5
  AST_PLAIN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_seg_en |-> ((pad_oe & ~(IIC_MASK | TMR_MASK)) == (dir_q & ~(IIC_MASK | TMR_MASK)))); // R6
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic             lcd_seg_en,
  input  logic             iic_route_en,
  input  logic [NPINS-1:0] tmr_oc_en,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_od
);
  localparam logic [NPINS-1:0] IIC_PINS = 8'h60;
  localparam logic [NPINS-1:0] TMR_PINS = 8'h0F;

  logic [NPINS-1:0] data_q, dir_q, sync_in, is_out, in_en;
  logic [NPINS-1:0] inp_view, port_view;

  gpio_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_in)
  );

  gpio_ovr_ctl #(.W(NPINS), .IIC_MASK(IIC_PINS), .TMR_MASK(TMR_PINS)) u_ovr (
    .clk(clk), .rst_n(rst_n), .lcd_seg_en(lcd_seg_en), .iic_route_en(iic_route_en),
    .tmr_oc_en(tmr_oc_en), .dir_q(dir_q), .data_q(data_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .is_out(is_out), .in_en(in_en)
  );

  assign inp_view  = sync_in & in_en;
  assign port_view = (is_out & data_q) | (~is_out & inp_view);

  always_comb begin
    case (bus_addr)
      ADR_DATA: bus_rdata = port_view;
      ADR_INP:  bus_rdata = inp_view;
      ADR_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_od == '0)); // R1
endmodule

// File: tb/gpio_port_ovr_tb.sv
module gpio_port_ovr_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic lcd_seg_en = 0, iic_route_en = 0;
  logic [7:0] tmr_oc_en = 0, pad_in = 0;
  logic [7:0] pad_oe, pad_out, pad_od;
  int checks = 0, failures = 0;
  logic [7:0] m_dir = 0, m_data = 0;

  always #10 clk = ~clk;

  gpio_port_ovr u_dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd2) m_dir = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // expected outputs from the requirements, pad assumed settled
  task automatic expect_all(output logic [7:0] oe, out, od, port, inp);
    for (int i = 0; i < 8; i++) begin
      oe[i] = 0; out[i] = 0; od[i] = 0; port[i] = pad_in[i]; inp[i] = pad_in[i];
      if (lcd_seg_en) begin
        port[i] = 0; inp[i] = 0;
      end else if ((i == 6 || i == 5) && iic_route_en) begin
        od[i] = 1; oe[i] = ~m_data[i]; port[i] = m_data[i];
      end else if ((i <= 3 && tmr_oc_en[i]) || m_dir[i]) begin
        oe[i] = 1; out[i] = m_data[i]; port[i] = m_data[i];
      end
    end
  endtask

  task automatic check_state(string tag);
    logic [7:0] eo, eout, eod, ep, ei, r;
    expect_all(eo, eout, eod, ep, ei);
    chk({tag, " oe"}, pad_oe, eo);
    chk({tag, " out"}, pad_out, eout);
    chk({tag, " od"}, pad_od, eod);
    rd(2'd0, r); chk({tag, " R7 port"}, r, ep);
    rd(2'd1, r); chk({tag, " R8 inp"}, r, ei);
    rd(2'd2, r); chk({tag, " R9 dir"}, r, m_dir);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd1234));
    pad_in = 8'hA5;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 8'h00);
    rd(2'd2, r); chk("R1 dir in reset", r, 8'h00);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 od after reset", pad_od, 8'h00);
    rd(2'd0, r); chk("R1 R7 port after reset", r, 8'hA5);

    // R2 plain direction
    wr(2'd0, 8'h3C); wr(2'd2, 8'hF0);
    repeat (2) @(negedge clk);
    check_state("R2 dir");

    // R9 read-only and unmapped writes ignored
    wr(2'd1, 8'hFF); wr(2'd3, 8'h55);
    m_data = 8'h3C; m_dir = 8'hF0;
    check_state("R9 ro write");
    rd(2'd3, r); chk("R9 addr3 reads 0", r, 8'h00);

    // R3 LCD beats everything
    lcd_seg_en = 1; iic_route_en = 1; tmr_oc_en = 8'hFF;
    @(negedge clk); check_state("R3 lcd");
    lcd_seg_en = 0;

    // R4 open drain on 6/5, data 1 on 6, 0 on 5
    wr(2'd0, 8'h40); wr(2'd2, 8'h00); tmr_oc_en = 0;
    @(negedge clk); check_state("R4 iic");
    chk("R4 pin6 released pin5 driven", pad_oe & 8'h60, 8'h20);
    iic_route_en = 0;

    // R5 timer forces output, R6 upper timer bits ignored
    tmr_oc_en = 8'hF5;
    @(negedge clk); check_state("R5 R6 tmr");
    chk("R6 pins 7/4 off", pad_oe & 8'h90, 8'h00);
    tmr_oc_en = 0;

    // R8 latency: input pins
    wr(2'd2, 8'h00); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk); rd(2'd1, r); chk("R8 one edge old", r, 8'h00);
    @(negedge clk); rd(2'd1, r); chk("R8 two edges new", r, 8'h96);
    rd(2'd0, r); chk("R8 R7 port new", r, 8'h96);

    // random mix
    for (int k = 0; k < 300; k++) begin
      wr(2'd0, 8'($urandom)); wr(2'd2, 8'($urandom));
      @(negedge clk);
      lcd_seg_en = ($urandom % 5) == 0;
      iic_route_en = $urandom % 2;
      tmr_oc_en = 8'($urandom);
      pad_in = 8'($urandom);
      repeat (3) @(negedge clk);
      check_state("R2 R3 R4 R5 R6 R7 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule